// File: doc/BRIEF.md
# OTP Fuse Word Programming Sequencer

This block burns a run of 32-bit words into a one-time-programmable fuse array, one bit at a time. A caller gives a first word index and a word count on a one-cycle start strobe. The block first checks that the whole run fits inside the array. It then wakes the fuse macro and walks through its enable sequence. For each word it takes one data word from a valid/ready stream. Every bit of that word gets its own timed write pulse, first into the main cell and then into the spare (redundancy) cell. At the end the block powers the macro down in a fixed order and raises a one-cycle done.

All waits are given in nanoseconds, together with the clock frequency in MHz, and are turned into cycle counts when the block is built. A single shared down-counter times every wait. A run that does not fit is refused at once: done and the error flag rise together and no macro pin moves. The error flag stays up until the next accepted start. A start that arrives while a run is in progress has no effect.

Top module: `otp_prog_seq`

## Requirements
- R1: A start whose index is at or above FUSE_WORDS, or whose index plus count exceeds FUSE_WORDS, gives done=1 and err=1 together for exactly the one cycle after the start edge. No macro pin leaves its idle value of 0 and no stream word is taken.
- R2: An accepted start powers the macro up in this order. First comes one cycle with only m_stdby=1. Next comes one cycle that adds m_trim=1. Then m_tmode=2'b10 (the program code) is held for the mode-setup time, while address, redundancy select, bit index, data and write enable stay at 0.
- R3: After the mode setup, one cycle adds m_ce=1 and the next cycle adds m_prog=1.
- R4: wd_ready is high only while the block waits for the next word, and one handshake takes exactly one word. The next word is not requested until all 64 pulses of the current word are finished.
- R5: Word k of a run (counting from 0) is programmed with m_addr = start_idx + k. The address is 0 from the start edge until the first word is taken.
- R6: Within a word, m_red=0 is used with m_bit stepping 0 to 31, then m_red=1 with m_bit 0 to 31. Once the word is done, m_red and m_bit return to 0.
- R7: For each bit, m_bit and m_din (the data bit at that index) are held with m_we=0 for the address-setup time. Then m_we=1 is held for the pulse width, and then m_we=0 for the pulse interval. The bit index and data do not change during a pulse.
- R8: Shutdown goes one step per cycle. First write enable is confirmed off, then m_prog drops, then m_ce, then m_tmode goes to 0, then m_trim drops, and finally m_stdby drops. done=1 and err=0 appear in that final cycle only.
- R9: err holds its last result while idle and is cleared by the next in-bounds start.
- R10: An in-bounds start with a count of 0 runs the full power-up and shutdown and takes no word.
- R11: Each wait lasts ceil(ns * CLK_MHZ / 1000) cycles, with a minimum of 1. The defaults are 1000 ns for mode setup, 1000 ns for address setup, 20000 ns for the pulse width and 5000 ns for the pulse interval.
- R12: A start strobe that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to program a run |
| start_idx | input | AW+1 | First word index of the run |
| word_cnt | input | AW+1 | Number of words in the run |
| wd_valid | input | 1 | Data word present |
| wd_data | input | WORD_W | Data word to burn |
| wd_ready | output | 1 | Block is ready to take a word |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run was refused by the bounds check |
| m_stdby | output | 1 | Macro awake (0 = deep standby) |
| m_trim | output | 1 | Macro trim/repair enable |
| m_tmode | output | 2 | Macro test-mode code |
| m_ce | output | 1 | Macro enable |
| m_prog | output | 1 | Macro program-mode enable |
| m_addr | output | AW | Word address |
| m_red | output | 1 | Redundancy cell select |
| m_bit | output | BW | Bit index within the word |
| m_din | output | 1 | Bit value to burn |
| m_we | output | 1 | Write pulse |

## Verification
The bench builds the block with FUSE_WORDS=16 and CLK_MHZ=2. This gives waits of 2, 2, 40 and 10 cycles. A full word then takes about 3,300 cycles, so several multi-word runs fit in the run. The 16-word array lets the bench hit the exact edges of the bounds rule: index 15 with count 1, index 15 with count 2, and index 16. It also exercises word stalls between handshakes and a start pulse during a run. A stub fuse array ORs in each pulsed bit, so both redundancy copies of every word can be compared against the data that was sent.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_ERR,
        S_WAKE,
        S_TRIM,
        S_MSET,
        S_CEON,
        S_PGON,
        S_WAIT,
        S_SETUP,
        S_PULSE,
        S_GAP,
        S_OFF_WE,
        S_OFF_PG,
        S_OFF_CE,
        S_OFF_TM,
        S_OFF_TR,
        S_OFF_SB
    } seq_state_e;

    localparam logic [1:0] TMODE_PROG = 2'b10;
    localparam logic [1:0] TMODE_OFF  = 2'b00;

    typedef struct packed {
        logic       stdby;
        logic       trim;
        logic [1:0] tmode;
        logic       ce;
        logic       prog;
        logic       we;
    } macro_ctl_t;

    // cycles = ceil(ns * mhz / 1000), never below one
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/otp_dly_timer.sv
module otp_dly_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_bound_chk.sv
module otp_bound_chk #(
    parameter int FUSE_WORDS = 4096,
    parameter int IW         = 13
) (
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] word_cnt,
    output logic          reject
);
    localparam int       IW1 = IW + 1;
    localparam logic [IW:0] LIM = IW1'(FUSE_WORDS);

    logic [IW:0] end_ext;
    logic        idx_over;

    assign end_ext = {1'b0, start_idx} + {1'b0, word_cnt};

    generate
        if (FUSE_WORDS == (1 << (IW - 1))) begin : g_pow2
            // index beyond the array exactly when its top bit is set
            assign idx_over = start_idx[IW-1];
        end else begin : g_any
            assign idx_over = ({1'b0, start_idx} >= LIM);
        end
    endgenerate

    assign reject = idx_over || (end_ext > LIM);
endmodule

// File: rtl/otp_bit_walk.sv
module otp_bit_walk #(
    parameter int BITS = 32,
    parameter int BW   = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [BW-1:0] bit_idx,
    output logic          red,
    output logic          last
);
    localparam logic [BW-1:0] TOP = BW'(BITS - 1);

    logic [BW-1:0] bit_q;
    logic          red_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bit_q <= '0;
            red_q <= 1'b0;
        end else if (step) begin
            if (bit_q == TOP) begin
                bit_q <= '0;
                red_q <= 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign bit_idx = bit_q;
    assign red     = red_q;
    assign last    = red_q && (bit_q == TOP);
endmodule

// File: rtl/otp_prog_fsm.sv
module otp_prog_fsm
    import otp_prog_pkg::*;
#(
    parameter int AW     = 12,
    parameter int IW     = 13,
    parameter int BW     = 5,
    parameter int WORD_W = 32,
    parameter int TW     = 12,
    parameter int D_MS   = 1,
    parameter int D_AS   = 1,
    parameter int D_PW   = 1,
    parameter int D_PI   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              reject,
    input  logic [IW-1:0]     word_cnt,
    input  logic [AW-1:0]     start_lo,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    input  logic              tmr_exp,
    input  logic              walk_last,
    input  logic [BW-1:0]     walk_bit,
    output logic              tmr_ld,
    output logic [TW-1:0]     tmr_val,
    output logic              walk_clr,
    output logic              walk_step,
    output logic              wd_ready,
    output logic [AW-1:0]     addr,
    output logic              din,
    output macro_ctl_t        ctl,
    output logic              done,
    output logic              err
);
    localparam logic [TW-1:0] LD_MS = TW'(D_MS - 1);
    localparam logic [TW-1:0] LD_AS = TW'(D_AS - 1);
    localparam logic [TW-1:0] LD_PW = TW'(D_PW - 1);
    localparam logic [TW-1:0] LD_PI = TW'(D_PI - 1);
    localparam logic [IW-1:0] ONE   = IW'(1);

    seq_state_e          st_q, st_d;
    logic [IW-1:0]       rem_q;
    logic [AW-1:0]       idx_q;
    logic [AW-1:0]       addr_q;
    logic [WORD_W-1:0]   data_q;
    logic                err_q;
    logic                accept, word_end, launch;

    always_comb begin
        st_d      = st_q;
        tmr_ld    = 1'b0;
        tmr_val   = '0;
        walk_clr  = 1'b0;
        walk_step = 1'b0;
        accept    = 1'b0;
        word_end  = 1'b0;
        launch    = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    if (reject) begin
                        st_d = S_ERR;
                    end else begin
                        st_d   = S_WAKE;
                        launch = 1'b1;
                    end
                end
            end
            S_ERR:  st_d = S_IDLE;
            S_WAKE: st_d = S_TRIM;
            S_TRIM: begin
                st_d    = S_MSET;
                tmr_ld  = 1'b1;
                tmr_val = LD_MS;
            end
            S_MSET: if (tmr_exp) st_d = S_CEON;
            S_CEON: st_d = S_PGON;
            S_PGON: st_d = (rem_q == '0) ? S_OFF_WE : S_WAIT;
            S_WAIT: begin
                if (wd_valid) begin
                    accept  = 1'b1;
                    st_d    = S_SETUP;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_AS;
                end
            end
            S_SETUP: begin
                if (tmr_exp) begin
                    st_d    = S_PULSE;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_PW;
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    st_d    = S_GAP;
                    tmr_ld  = 1'b1;
                    tmr_val = LD_PI;
                end
            end
            S_GAP: begin
                if (tmr_exp) begin
                    if (walk_last) begin
                        walk_clr = 1'b1;
                        word_end = 1'b1;
                        st_d     = (rem_q == ONE) ? S_OFF_WE : S_WAIT;
                    end else begin
                        walk_step = 1'b1;
                        st_d      = S_SETUP;
                        tmr_ld    = 1'b1;
                        tmr_val   = LD_AS;
                    end
                end
            end
            S_OFF_WE: st_d = S_OFF_PG;
            S_OFF_PG: st_d = S_OFF_CE;
            S_OFF_CE: st_d = S_OFF_TM;
            S_OFF_TM: st_d = S_OFF_TR;
            S_OFF_TR: st_d = S_OFF_SB;
            S_OFF_SB: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            rem_q  <= '0;
            idx_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && start) begin
                err_q <= reject;
            end
            if (launch) begin
                rem_q  <= word_cnt;
                idx_q  <= start_lo;
                addr_q <= '0;
            end
            if (accept) begin
                data_q <= wd_data;
                addr_q <= idx_q;
            end
            if (word_end) begin
                rem_q <= rem_q - 1'b1;
                idx_q <= idx_q + 1'b1;
            end
            if (st_q == S_OFF_SB) begin
                addr_q <= '0;
            end
        end
    end

    logic bit_phase;
    assign bit_phase = (st_q == S_SETUP) || (st_q == S_PULSE) || (st_q == S_GAP);

    always_comb begin
        ctl.stdby = (st_q >= S_WAKE) && (st_q <= S_OFF_TR);
        ctl.trim  = (st_q >= S_TRIM) && (st_q <= S_OFF_TM);
        ctl.tmode = ((st_q >= S_MSET) && (st_q <= S_OFF_CE)) ? TMODE_PROG : TMODE_OFF;
        ctl.ce    = (st_q >= S_CEON) && (st_q <= S_OFF_PG);
        ctl.prog  = (st_q >= S_PGON) && (st_q <= S_OFF_WE);
        ctl.we    = (st_q == S_PULSE);
    end

    assign wd_ready = (st_q == S_WAIT);
    assign addr     = addr_q;
    assign din      = bit_phase && data_q[walk_bit];
    assign done     = (st_q == S_ERR) || (st_q == S_OFF_SB);
    assign err      = err_q;
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int FUSE_WORDS = 4096,
    parameter int WORD_W     = 32,
    parameter int CLK_MHZ    = 125,
    parameter int T_MS_NS    = 1000,
    parameter int T_AS_NS    = 1000,
    parameter int T_PW_NS    = 20000,
    parameter int T_PI_NS    = 5000,
    localparam int AW        = $clog2(FUSE_WORDS),
    localparam int IW        = AW + 1,
    localparam int BW        = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IW-1:0]     start_idx,
    input  logic [IW-1:0]     word_cnt,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              done,
    output logic              err,
    output logic              m_stdby,
    output logic              m_trim,
    output logic [1:0]        m_tmode,
    output logic              m_ce,
    output logic              m_prog,
    output logic [AW-1:0]     m_addr,
    output logic              m_red,
    output logic [BW-1:0]     m_bit,
    output logic              m_din,
    output logic              m_we
);
    localparam int D_MS  = ns_to_cyc(T_MS_NS, CLK_MHZ);
    localparam int D_AS  = ns_to_cyc(T_AS_NS, CLK_MHZ);
    localparam int D_PW  = ns_to_cyc(T_PW_NS, CLK_MHZ);
    localparam int D_PI  = ns_to_cyc(T_PI_NS, CLK_MHZ);
    localparam int D_MAX = max_of4(D_MS, D_AS, D_PW, D_PI);
    localparam int TW    = $clog2(D_MAX + 1);

    logic          reject;
    logic          tmr_ld, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          walk_clr, walk_step, walk_last, walk_red;
    logic [BW-1:0] walk_bit;
    macro_ctl_t    ctl;

    otp_bound_chk #(.FUSE_WORDS(FUSE_WORDS), .IW(IW)) u_bound (
        .start_idx (start_idx),
        .word_cnt  (word_cnt),
        .reject    (reject)
    );

    otp_dly_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    otp_bit_walk #(.BITS(WORD_W), .BW(BW)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .clr     (walk_clr),
        .step    (walk_step),
        .bit_idx (walk_bit),
        .red     (walk_red),
        .last    (walk_last)
    );

    otp_prog_fsm #(
        .AW(AW), .IW(IW), .BW(BW), .WORD_W(WORD_W), .TW(TW),
        .D_MS(D_MS), .D_AS(D_AS), .D_PW(D_PW), .D_PI(D_PI)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .reject    (reject),
        .word_cnt  (word_cnt),
        .start_lo  (start_idx[AW-1:0]),
        .wd_valid  (wd_valid),
        .wd_data   (wd_data),
        .tmr_exp   (tmr_exp),
        .walk_last (walk_last),
        .walk_bit  (walk_bit),
        .tmr_ld    (tmr_ld),
        .tmr_val   (tmr_val),
        .walk_clr  (walk_clr),
        .walk_step (walk_step),
        .wd_ready  (wd_ready),
        .addr      (m_addr),
        .din       (m_din),
        .ctl       (ctl),
        .done      (done),
        .err       (err)
    );

    assign m_stdby = ctl.stdby;
    assign m_trim  = ctl.trim;
    assign m_tmode = ctl.tmode;
    assign m_ce    = ctl.ce;
    assign m_prog  = ctl.prog;
    assign m_we    = ctl.we;
    assign m_red   = walk_red;
    assign m_bit   = walk_bit;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int AW = 12,
    parameter int BW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          done,
    input logic          err,
    input logic          wd_valid,
    input logic          wd_ready,
    input logic          m_stdby,
    input logic          m_trim,
    input logic [1:0]    m_tmode,
    input logic          m_ce,
    input logic          m_prog,
    input logic [AW-1:0] m_addr,
    input logic          m_red,
    input logic [BW-1:0] m_bit,
    input logic          m_din,
    input logic          m_we
);
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!m_stdby && !m_trim && m_tmode == 2'b00 && !m_ce && !m_prog && !m_we)); // R1
    AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> $past(start)); // R1
    AST_CE_NEEDS_SETUP: assert property (@(posedge clk) disable iff (rst)
        m_ce |-> (m_stdby && m_trim && m_tmode == 2'b10)); // R2
    AST_PROG_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        m_prog |-> m_ce); // R3
    AST_WAIT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        wd_ready |-> (!m_we && !m_red && m_prog)); // R4
    AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        (wd_valid && wd_ready) |=> !wd_ready); // R4
    AST_WE_NEEDS_PROG: assert property (@(posedge clk) disable iff (rst)
        m_we |-> m_prog); // R7
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (m_we && $past(m_we)) |-> ($stable(m_addr) && $stable(m_bit) && $stable(m_red) && $stable(m_din))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_STBY_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(m_stdby) |-> (done && !err && !m_trim)); // R8
    AST_TRIM_AFTER_TM: assert property (@(posedge clk) disable iff (rst)
        $fell(m_trim) |-> (m_tmode == 2'b00 && !m_ce && m_stdby)); // R8
endmodule

bind otp_prog_seq otp_prog_seq_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .done     (done),
    .err      (err),
    .wd_valid (wd_valid),
    .wd_ready (wd_ready),
    .m_stdby  (m_stdby),
    .m_trim   (m_trim),
    .m_tmode  (m_tmode),
    .m_ce     (m_ce),
    .m_prog   (m_prog),
    .m_addr   (m_addr),
    .m_red    (m_red),
    .m_bit    (m_bit),
    .m_din    (m_din),
    .m_we     (m_we)
);

// File: tb/otp_prog_seq_tb_top.sv
module otp_prog_seq_tb_top;
    localparam int NW  = 16;
    localparam int MHZ = 2;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // R11: waits derived from the default ns values
    localparam int CMS = cyc(1000);
    localparam int CAS = cyc(1000);
    localparam int CPW = cyc(20000);
    localparam int CPI = cyc(5000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  start_idx = '0;
    logic [4:0]  word_cnt = '0;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_ready, done, err;
    logic        m_stdby, m_trim, m_ce, m_prog, m_red, m_din, m_we;
    logic [1:0]  m_tmode;
    logic [3:0]  m_addr;
    logic [4:0]  m_bit;

    always #4 clk = ~clk;

    otp_prog_seq #(.FUSE_WORDS(NW), .CLK_MHZ(MHZ)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_idx(start_idx), .word_cnt(word_cnt),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready), .done(done), .err(err),
        .m_stdby(m_stdby), .m_trim(m_trim), .m_tmode(m_tmode), .m_ce(m_ce), .m_prog(m_prog),
        .m_addr(m_addr), .m_red(m_red), .m_bit(m_bit), .m_din(m_din), .m_we(m_we)
    );

    typedef struct packed {
        bit       sb; bit tr; bit [1:0] tm; bit ce; bit pg;
        bit [3:0] ad; bit rd; bit [4:0] bt; bit di; bit we;
        bit       rdy; bit dn; bit er; bit wt;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] dq[$];
    int          compared = 0;
    int          mismatched = 0;
    int          prints = 0;
    int          hold = 0;
    int          gap_cfg = 0;
    bit          last_err = 0;
    bit          model_on = 0;
    logic [31:0] fz [0:1][0:NW-1];

    // fuse stub: OR in the bit on each write pulse
    initial begin
        for (int r = 0; r < 2; r++)
            for (int a = 0; a < NW; a++) fz[r][a] = '0;
    end
    always @(posedge m_we) begin
        fz[m_red][m_addr][m_bit] = fz[m_red][m_addr][m_bit] | m_din;
    end

    task automatic fail_line(input string req, input int act, input int expv);
        mismatched++;
        if (prints < 30) begin
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, expv);
            prints++;
        end
    endtask

    task automatic put(input exp_t e, input int n);
        for (int i = 0; i < n; i++) expq.push_back(e);
    endtask

    task automatic gen_err();
        exp_t e;
        e = '0; e.dn = 1; e.er = 1;
        put(e, 1);
    endtask

    task automatic gen_run(input int s, input int n, input logic [31:0] w[$]);
        exp_t e;
        e = '0;
        e.sb = 1; put(e, 1);
        e.tr = 1; put(e, 1);
        e.tm = 2'b10; put(e, CMS);
        e.ce = 1; put(e, 1);
        e.pg = 1; put(e, 1);
        for (int k = 0; k < n; k++) begin
            e.rdy = 1; e.wt = 1; put(e, 1);
            e.rdy = 0; e.wt = 0;
            e.ad = 4'(s + k);
            for (int r = 0; r < 2; r++) begin
                for (int b = 0; b < 32; b++) begin
                    e.rd = r[0]; e.bt = 5'(b); e.di = w[k][b];
                    e.we = 0; put(e, CAS);
                    e.we = 1; put(e, CPW);
                    e.we = 0; put(e, CPI);
                end
            end
            e.rd = 0; e.bt = 0; e.di = 0;
        end
        put(e, 1);
        e.pg = 0; put(e, 1);
        e.ce = 0; put(e, 1);
        e.tm = 0; put(e, 1);
        e.tr = 0; put(e, 1);
        e.sb = 0; e.dn = 1; put(e, 1);
    endtask

    // per-cycle comparison against the expected trace
    initial begin
        exp_t e;
        bit   vs;
        wait (model_on);
        forever begin
            @(negedge clk);
            if (expq.size() > 0) e = expq[0];
            else begin e = '0; e.er = last_err; end
            compared++;
            if ({m_stdby, m_trim, m_tmode, m_ce, m_prog} != {e.sb, e.tr, e.tm, e.ce, e.pg})
                fail_line("R2 R3 R8 enables", {m_stdby, m_trim, m_tmode, m_ce, m_prog},
                          {e.sb, e.tr, e.tm, e.ce, e.pg});
            if (m_addr != e.ad) fail_line("R5 addr", m_addr, e.ad);
            if ({m_red, m_bit} != {e.rd, e.bt}) fail_line("R6 red/bit", {m_red, m_bit}, {e.rd, e.bt});
            if (m_din != e.di) fail_line("R7 din", m_din, e.di);
            if (m_we != e.we) fail_line("R7 we", m_we, e.we);
            if (wd_ready != e.rdy) fail_line("R4 ready", wd_ready, e.rdy);
            if ({done, err} != {e.dn, e.er}) fail_line("R1 R9 done/err", {done, err}, {e.dn, e.er});
            vs = wd_valid;
            @(posedge clk);
            if (expq.size() > 0 && (!expq[0].wt || vs)) begin
                last_err = expq[0].er;
                void'(expq.pop_front());
            end
        end
    end

    // word stream source
    initial begin
        bit hs;
        forever begin
            @(posedge clk);
            hs = wd_valid && wd_ready;
            #1;
            if (hs) begin
                void'(dq.pop_front());
                hold = gap_cfg;
            end else if (hold > 0) begin
                hold--;
            end
            wd_valid = (dq.size() > 0) && (hold == 0);
            wd_data  = (dq.size() > 0) ? dq[0] : 32'h0;
        end
    end

    task automatic pulse_start(input int s, input int n);
        @(posedge clk); #1;
        start = 1; start_idx = 5'(s); word_cnt = 5'(n);
        @(posedge clk); #1;
        start = 0;
    endtask

    task automatic drain();
        while (expq.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic chk(input string req, input int act, input int expv);
        compared++;
        if (act != expv) fail_line(req, act, expv);
    endtask

    initial begin
        logic [31:0] w[$];
        int wd;
        wd = 0;
        fork
            begin
                while (wd < 120000) begin @(posedge clk); wd++; end
                mismatched++;
                $display("FAIL watchdog: actual %0d expected below 120000 cycles", wd);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        join_none

        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 reset idle pins", {m_stdby, m_trim, m_tmode, m_ce, m_prog, m_we, wd_ready, done, err}, 0);
        model_on = 1;

        // R1: index equal to array size
        pulse_start(16, 1); gen_err(); drain();
        chk("R9 err held", err, 1);
        // R1: run past end by one
        pulse_start(15, 2); gen_err(); drain();
        // R1: edge case index 15 count 1 is legal -> checked in T5 below

        // R10: zero-length run, also clears err (R9)
        pulse_start(3, 0); w = {}; gen_run(3, 0, w); drain();
        chk("R9 err cleared", err, 0);

        // R5 R6 R7: two words with a stall between words, start during run (R12)
        w = {32'hA5C3_0F81, 32'h8000_0001};
        gap_cfg = 7;
        dq.push_back(w[0]); dq.push_back(w[1]);
        pulse_start(14, 2); gen_run(14, 2, w);
        repeat (500) @(posedge clk);
        @(posedge clk); #1 start = 1; start_idx = 5'd16; word_cnt = 5'd1;
        @(posedge clk); #1 start = 0;
        drain();

        // R4: first word withheld for 40 cycles, index 15 count 1 (R1 boundary)
        w = {32'h7FFE_1234};
        gap_cfg = 0;
        hold = 40;
        dq.push_back(w[0]);
        pulse_start(15, 1); gen_run(15, 1, w); drain();

        // fuse stub contents: both redundancy copies of each word (R6)
        chk("R6 main copy word14", fz[0][14], 32'hA5C3_0F81);
        chk("R6 spare copy word14", fz[1][14], 32'hA5C3_0F81);
        chk("R6 main copy word15", fz[0][15], 32'h8000_0001 | 32'h7FFE_1234);
        chk("R6 spare copy word15", fz[1][15], 32'h8000_0001 | 32'h7FFE_1234);
        chk("R1 untouched word0", fz[0][0] | fz[1][0], 0);
        chk("R10 untouched word3", fz[0][3] | fz[1][3], 0);
        chk("R4 stream drained", dq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule